// File: doc/BRIEF.md
# Buffered SPI master engine

This block is a master-only serial peripheral interface engine. A host writes bytes into a one-entry transmit holding register and reads received bytes from a small receive queue. The engine drives the serial clock and the outgoing data line and samples the incoming data line. Three flags report the state of a transfer: the holding register can take a byte, the last byte has fully left the shifter, and received data is waiting. Each flag is ANDed with its own enable to form an interrupt output.

One transfer controller runs one transmit shift register and one receive shift register together, so every transmitted bit has a received bit. Clock polarity, clock phase and bit order are set by static configuration inputs. The serial rate comes from a 12-bit divider: each half of the serial clock lasts `cfg_div + 1` system clock cycles, so the fastest serial clock is half the system clock. When a byte is waiting at the end of the current byte, it is loaded at once and the clock continues without a pause. Received bytes are kept in a two-entry queue placed after the receive shift register.

Top module: `spim_engine`

## Requirements
- R1: After reset, `tx_empty` is 1, `tx_done`, `rx_avail` and `rx_overrun` are 0, and `sck` equals `cfg_cpol`.
- R2: When no transfer runs, `sck` rests at `cfg_cpol`. Each bit takes one full `sck` period. With `cfg_cpha`=0, `sck` holds its idle level for the first half of the bit and toggles at mid-bit. With `cfg_cpha`=1, it toggles at the start of the bit and returns at mid-bit.
- R3: `mosi` changes only at bit boundaries. With `cfg_cpha`=0, the first bit is on `mosi` half a bit before the first `sck` edge. `miso` is sampled at mid-bit, which is the leading edge for phase 0 and the trailing edge for phase 1.
- R4: `cfg_lsb_first`=1 sends bit 0 first and `cfg_lsb_first`=0 sends bit 7 first. A received byte is assembled in the same order, so the first bit on `miso` lands in bit 0 or in bit 7 respectively.
- R5: Each half period of `sck` lasts `cfg_div`+1 system clock cycles, so the same sampling edge repeats every 2×(`cfg_div`+1) cycles. `cfg_div`=0 gives half the system clock.
- R6: `tx_empty` is 1 exactly when the holding register is free. A byte written while another is shifting starts right after the last bit of that byte, with no extra `sck` period between the two bytes.
- R7: A `tx_wr` while `tx_empty` is 0 is dropped. It changes neither the byte in the shifter nor the byte already queued.
- R8: `tx_done` becomes 1 when the last bit of a byte completes and no byte is queued. It returns to 0 when a write is accepted.
- R9: The receive queue holds up to 2 bytes in arrival order. `rx_data` shows the oldest byte, a pulse on `rx_rd` removes it, and `rx_avail` is 1 while the queue is not empty.
- R10: A byte that completes while the receive queue is full is discarded and the queued bytes are kept. `rx_overrun` goes to 1 and stays at 1 until the next `rx_rd`.
- R11: `irq_tx_empty`, `irq_tx_done` and `irq_rx_avail` each equal their flag ANDed with the matching enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 goes first, 0: bit 7 goes first |
| cfg_div | input | 12 | Divider; each `sck` half lasts `cfg_div`+1 clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| ie_tx_empty | input | 1 | Enable for `irq_tx_empty` |
| ie_tx_done | input | 1 | Enable for `irq_tx_done` |
| ie_rx_avail | input | 1 | Enable for `irq_rx_avail` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| tx_empty | output | 1 | Holding register can take a byte |
| tx_done | output | 1 | Shifter and holding register have drained |
| rx_avail | output | 1 | Received data is waiting |
| rx_overrun | output | 1 | A received byte was discarded |
| irq_tx_empty | output | 1 | Interrupt for `tx_empty` |
| irq_tx_done | output | 1 | Interrupt for `tx_done` |
| irq_rx_avail | output | 1 | Interrupt for `rx_avail` |

## Verification
The bench models a slave that samples `mosi` and shifts `miso` on the edges the chosen mode calls for, across all four modes and both bit orders. A design with the phase or polarity swapped would make the slave read the wrong bits and would return a corrupted byte. Sampling-edge timestamps are compared to the divider. This catches an off-by-one half period, and in back-to-back traffic it catches an idle period inserted between bytes. Further tests write to a full holding register and fill the receive queue beyond its depth. A design that overwrote the queued byte, or that kept the newest received byte instead of the oldest, would show the wrong byte or the wrong overrun state.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W   = 8;
    localparam int DIV_W    = 12;
    localparam int RX_DEPTH = 2;
    localparam int NUM_IRQ  = 3;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_mode_t;

    // Serial clock level for the current half of a bit while a transfer runs.
    function automatic logic sck_level(input spi_mode_t m, input logic second_half);
        return m.cpol ^ m.cpha ^ second_half;
    endfunction

endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int DIV_W = spim_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> !tick); // R5

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (cnt == '0)); // R5

endmodule

// File: rtl/spim_txq.sv
module spim_txq #(
    parameter int W = spim_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         accept,
    output logic         valid,
    output logic [W-1:0] data
);
    assign accept = wr && (!valid || pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (accept) begin
                data <= wdata;
            end
            if (accept) begin
                valid <= 1'b1;
            end else if (pop) begin
                valid <= 1'b0;
            end
        end
    end

    AST_TXQ_FULL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (valid && wr && !pop) |=> (valid && $stable(data))); // R7

    AST_TXQ_POP_VALID: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid); // R6

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int W = spim_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  spi_mode_t    mode,
    input  logic         tick,
    input  logic         q_valid,
    input  logic [W-1:0] q_data,
    input  logic         miso,
    output logic         q_pop,
    output logic         run,
    output logic         sck,
    output logic         mosi,
    output logic         rx_push,
    output logic [W-1:0] rx_byte,
    output logic         done_pulse
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    sh_state_e        st;
    logic [CNT_W-1:0] bitcnt;
    logic             half;
    logic [W-1:0]     tx_sr;
    logic [W-1:0]     rx_sr;
    logic             bit_end;
    logic             last;

    assign run     = (st == SH_RUN);
    assign last    = (bitcnt == LAST_BIT);
    assign bit_end = run && tick && half;

    assign q_pop      = (!run && q_valid) || (bit_end && last && q_valid);
    assign rx_push    = bit_end && last;
    assign rx_byte    = rx_sr;
    assign done_pulse = bit_end && last && !q_valid;

    assign sck  = run ? sck_level(mode, half) : mode.cpol;
    assign mosi = mode.lsb_first ? tx_sr[0] : tx_sr[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SH_IDLE;
            bitcnt <= '0;
            half   <= 1'b0;
            tx_sr  <= '0;
            rx_sr  <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (q_valid) begin
                        tx_sr  <= q_data;
                        st     <= SH_RUN;
                        half   <= 1'b0;
                        bitcnt <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (!half) begin
                            rx_sr <= mode.lsb_first ? {miso, rx_sr[W-1:1]}
                                                    : {rx_sr[W-2:0], miso};
                            half  <= 1'b1;
                        end else begin
                            half <= 1'b0;
                            if (last) begin
                                bitcnt <= '0;
                                if (q_valid) begin
                                    tx_sr <= q_data;
                                end else begin
                                    st <= SH_IDLE;
                                end
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                tx_sr  <= mode.lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
                            end
                        end
                    end
                end
            endcase
        end
    end

    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (rst)
        (run && !(tick && half)) |=> $stable(mosi)); // R3

    AST_SCK_SETTLES: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(sck)); // R2

endmodule

// File: rtl/spim_rxbuf.sv
module spim_rxbuf #(
    parameter int W     = spim_pkg::DATA_W,
    parameter int DEPTH = spim_pkg::RX_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         avail,
    output logic         overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_pop, do_push, full;

    assign full    = (cnt == CNT_FULL);
    assign do_pop  = pop && (cnt != '0);
    assign do_push = push && (!full || do_pop);
    assign head    = mem[rp];
    assign avail   = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) begin
                wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt <= cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt <= cnt - 1'b1;
            end
            if (do_pop) begin
                overrun <= 1'b0;
            end else if (push && !do_push) begin
                overrun <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (do_push && wp == PTR_W'(g)) begin
                mem[g] <= pdata;
            end
        end
    end

    AST_RX_KEEP_OLDEST: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (overrun && $stable(head) && avail)); // R10

    AST_RX_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (overrun && pop) |=> !overrun); // R10

    AST_RX_POP_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(1) && pop && !push) |=> !avail); // R9

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int W     = spim_pkg::DATA_W,
    parameter int DIV_W = spim_pkg::DIV_W,
    parameter int DEPTH = spim_pkg::RX_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             tx_wr,
    input  logic [W-1:0]     tx_data,
    input  logic             rx_rd,
    output logic [W-1:0]     rx_data,
    input  logic             ie_tx_empty,
    input  logic             ie_tx_done,
    input  logic             ie_rx_avail,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             tx_empty,
    output logic             tx_done,
    output logic             rx_avail,
    output logic             rx_overrun,
    output logic             irq_tx_empty,
    output logic             irq_tx_done,
    output logic             irq_rx_avail
);
    spi_mode_t      mode;
    logic           tick, sh_run, q_pop, q_accept, q_valid;
    logic [W-1:0]   q_data, rx_byte;
    logic           rx_push, done_pulse;
    logic [NUM_IRQ-1:0] flag_vec, en_vec, irq_vec;

    assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

    spim_baud #(.DIV_W(DIV_W)) baud_i (
        .clk  (clk),
        .rst  (rst),
        .run  (sh_run),
        .div  (cfg_div),
        .tick (tick)
    );

    spim_txq #(.W(W)) txq_i (
        .clk    (clk),
        .rst    (rst),
        .wr     (tx_wr),
        .wdata  (tx_data),
        .pop    (q_pop),
        .accept (q_accept),
        .valid  (q_valid),
        .data   (q_data)
    );

    spim_shifter #(.W(W)) shifter_i (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .tick       (tick),
        .q_valid    (q_valid),
        .q_data     (q_data),
        .miso       (miso),
        .q_pop      (q_pop),
        .run        (sh_run),
        .sck        (sck),
        .mosi       (mosi),
        .rx_push    (rx_push),
        .rx_byte    (rx_byte),
        .done_pulse (done_pulse)
    );

    spim_rxbuf #(.W(W), .DEPTH(DEPTH)) rxbuf_i (
        .clk     (clk),
        .rst     (rst),
        .push    (rx_push),
        .pdata   (rx_byte),
        .pop     (rx_rd),
        .head    (rx_data),
        .avail   (rx_avail),
        .overrun (rx_overrun)
    );

    assign tx_empty = !q_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done <= 1'b0;
        end else if (q_accept) begin
            tx_done <= 1'b0;
        end else if (done_pulse) begin
            tx_done <= 1'b1;
        end
    end

    assign flag_vec = {rx_avail, tx_done, tx_empty};
    assign en_vec   = {ie_rx_avail, ie_tx_done, ie_tx_empty};

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        assign irq_vec[g] = flag_vec[g] & en_vec[g];
    end

    assign irq_tx_empty = irq_vec[0];
    assign irq_tx_done  = irq_vec[1];
    assign irq_rx_avail = irq_vec[2];

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (tx_empty && !sh_run)); // R8

    AST_DONE_RISE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> $past(rx_push)); // R8

endmodule

// File: tb/spim_engine_tb.sv
module spim_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_cpol, cfg_cpha, cfg_lsb_first;
    logic [11:0] cfg_div;
    logic        tx_wr, rx_rd;
    logic [7:0]  tx_data, rx_data;
    logic        ie_tx_empty, ie_tx_done, ie_rx_avail;
    logic        sck, mosi, miso;
    logic        tx_empty, tx_done, rx_avail, rx_overrun;
    logic        irq_tx_empty, irq_tx_done, irq_rx_avail;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spim_engine dut_i (
        .clk(clk), .rst(rst),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
        .cfg_div(cfg_div),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .ie_tx_empty(ie_tx_empty), .ie_tx_done(ie_tx_done), .ie_rx_avail(ie_rx_avail),
        .sck(sck), .mosi(mosi), .miso(miso),
        .tx_empty(tx_empty), .tx_done(tx_done), .rx_avail(rx_avail), .rx_overrun(rx_overrun),
        .irq_tx_empty(irq_tx_empty), .irq_tx_done(irq_tx_done), .irq_rx_avail(irq_rx_avail)
    );

    // ---------------- slave model ----------------
    logic [7:0]  slv_bytes [0:7];
    logic [63:0] mosi_bits;
    int          samp_cyc [0:63];
    int          nsamp = 0;
    logic        sck_q = 1'b0;
    logic        slv_clr = 1'b0;

    always @(negedge clk) begin
        if (slv_clr) begin
            nsamp = 0;
        end else if (sck !== sck_q && sck === ~(cfg_cpol ^ cfg_cpha) && nsamp < 64) begin
            mosi_bits[nsamp] = mosi;
            samp_cyc[nsamp]  = cyc;
            nsamp = nsamp + 1;
        end
        sck_q = sck;
    end

    always_comb begin
        logic [7:0] b;
        int idx, i;
        idx = (nsamp >> 3) > 7 ? 7 : (nsamp >> 3);
        i   = nsamp & 7;
        b   = slv_bytes[idx];
        miso = cfg_lsb_first ? b[i] : b[7-i];
    end

    function automatic logic [7:0] got_byte(input int k);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (cfg_lsb_first) r[i] = mosi_bits[8*k+i];
            else               r[7-i] = mosi_bits[8*k+i];
        end
        return r;
    endfunction

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk); tx_wr = 1'b1; tx_data = b;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic set_cfg(input logic pol, input logic pha, input logic lsb, input int div);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb; cfg_div = 12'(div);
        @(negedge clk); @(negedge clk);
        slv_clr = 1'b1;
        @(negedge clk); @(negedge clk);
        slv_clr = 1'b0;
    endtask

    task automatic wait_done();
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (tx_done) break;
        end
        chk("R8 tx_done after drain", tx_done, 1);
    endtask

    task automatic wait_tx_empty();
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (tx_empty) break;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 tx_done", tx_done, 0);
        chk("R1 rx_avail", rx_avail, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        chk("R1 sck idle", sck, cfg_cpol);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic lsb, input int div,
                          input logic [7:0] mb, input logic [7:0] sb);
        set_cfg(pol, pha, lsb, div);
        slv_bytes[0] = sb;
        chk("R2 sck idle level", sck, pol);
        host_write(mb);
        wait_done();
        chk("R2 sample edge count", nsamp, 8);
        chk("R3 mosi byte seen by slave", got_byte(0), mb);
        chk("R4 byte assembled from miso", rx_data, sb);
        chk("R5 sampling period", samp_cyc[1] - samp_cyc[0], 2 * (div + 1));
        chk("R2 sck back at idle", sck, pol);
        chk("R9 rx_avail set", rx_avail, 1);
        host_read();
        chk("R9 rx_avail cleared", rx_avail, 0);
    endtask

    task automatic t_divider();
        set_cfg(1'b0, 1'b1, 1'b0, 5);
        slv_bytes[0] = 8'h3C;
        host_write(8'hC3);
        wait_done();
        for (int i = 0; i < 7; i++)
            chk("R5 divider 5 period", samp_cyc[i+1] - samp_cyc[i], 12);
        chk("R4 msb-first data", rx_data, 8'h3C);
        host_read();
    endtask

    task automatic t_back_to_back();
        set_cfg(1'b1, 1'b0, 1'b1, 1);
        slv_bytes[0] = 8'h11; slv_bytes[1] = 8'hEE;
        host_write(8'hA5);
        wait_tx_empty();
        chk("R6 tx_empty while first byte shifts", tx_empty, 1);
        host_write(8'h5A);
        chk("R6 tx_empty low with byte queued", tx_empty, 0);
        wait_done();
        chk("R6 sixteen samples", nsamp, 16);
        for (int i = 0; i < 15; i++)
            chk("R6 no gap between bytes", samp_cyc[i+1] - samp_cyc[i], 4);
        chk("R6 first byte", got_byte(0), 8'hA5);
        chk("R6 second byte", got_byte(1), 8'h5A);
        chk("R9 oldest first", rx_data, 8'h11);
        host_read();
        chk("R9 second entry", rx_data, 8'hEE);
        host_read();
        chk("R9 queue empty", rx_avail, 0);
    endtask

    task automatic t_full_write();
        set_cfg(1'b0, 1'b0, 1'b0, 2);
        slv_bytes[0] = 8'h01; slv_bytes[1] = 8'h02;
        host_write(8'h81);
        wait_tx_empty();
        host_write(8'h42);
        host_write(8'hFF);
        chk("R7 queue still full", tx_empty, 0);
        wait_done();
        chk("R7 only two bytes sent", nsamp, 16);
        chk("R7 shifting byte intact", got_byte(0), 8'h81);
        chk("R7 queued byte intact", got_byte(1), 8'h42);
        host_read(); host_read();
        chk("R9 drained", rx_avail, 0);
    endtask

    task automatic t_overrun();
        set_cfg(1'b1, 1'b1, 1'b1, 0);
        slv_bytes[0] = 8'hD1; slv_bytes[1] = 8'hD2; slv_bytes[2] = 8'hD3;
        ie_rx_avail = 1'b0;
        host_write(8'h10); wait_done();
        chk("R11 irq_rx_avail masked", irq_rx_avail, 0);
        ie_rx_avail = 1'b1;
        @(negedge clk);
        chk("R11 irq_rx_avail enabled", irq_rx_avail, 1);
        host_write(8'h20); wait_done();
        chk("R10 no overrun at depth", rx_overrun, 0);
        host_write(8'h30); wait_done();
        chk("R10 overrun set", rx_overrun, 1);
        chk("R10 oldest kept", rx_data, 8'hD1);
        host_read();
        chk("R10 overrun cleared by read", rx_overrun, 0);
        chk("R10 second byte next", rx_data, 8'hD2);
        host_read();
        chk("R10 third byte dropped", rx_avail, 0);
    endtask

    task automatic t_irq();
        ie_tx_empty = 1'b0; ie_tx_done = 1'b0;
        @(negedge clk);
        chk("R11 irq_tx_empty masked", irq_tx_empty, 0);
        chk("R11 irq_tx_done masked", irq_tx_done, 0);
        ie_tx_empty = 1'b1; ie_tx_done = 1'b1;
        @(negedge clk);
        chk("R11 irq_tx_empty", irq_tx_empty, 1);
        chk("R11 irq_tx_done", irq_tx_done, tx_done);
        host_write(8'h77);
        chk("R8 tx_done cleared by write", tx_done, 0);
        wait_done();
        chk("R11 irq_tx_done after drain", irq_tx_done, 1);
        host_read();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        rst = 1'b1; tx_wr = 1'b0; rx_rd = 1'b0; tx_data = '0;
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_div = '0;
        ie_tx_empty = 1'b1; ie_tx_done = 1'b1; ie_rx_avail = 1'b1;
        for (int i = 0; i < 8; i++) slv_bytes[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mode(1'b0, 1'b0, 1'b0, 0, 8'hB4, 8'h6D);
        t_mode(1'b0, 1'b1, 1'b1, 1, 8'h1E, 8'hC7);
        t_mode(1'b1, 1'b0, 1'b1, 2, 8'h93, 8'h2A);
        t_mode(1'b1, 1'b1, 1'b0, 3, 8'h4F, 8'hF0);
        t_divider();
        t_back_to_back();
        t_full_write();
        t_overrun();
        t_irq();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule